// File: doc/BRIEF.md
# Fractional sync period marker

This block sits in a block-based streaming path where every block starts with a start-of-packet strobe and carries a block sequence number. It forwards the stream one register stage later and adds a sync flag to the first sample of selected blocks. The spacing between sync flags is set in samples, and that spacing need not be a whole number of blocks. The marker therefore alternates between periods of N and N+1 blocks. A remainder accumulator decides which length comes next, so the long-run average equals the configured sample count.

The start BSN, the sync period in samples and the block size in samples are input ports. They are sampled while reset is high. After reset is released, a bit-serial divider derives N and the remainder over CFG_W cycles. The marker then arms itself. It keeps the next expected sync BSN in a register and compares each block header against that register. No per-block division or search is needed. Status outputs show the next expected sync BSN, the length of the coming period and a sticky error flag. The error flag is set when the stream steps past the expected BSN without hitting it.

Top module: `frac_sync_marker`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_sync and err_o are 0.
- R2: out_valid, out_sop, out_bsn and out_data equal in_valid, in_sop, in_bsn and in_data of the previous cycle (latency of exactly one clock).
- R3: out_sync is 1 only in a cycle where out_valid and out_sop are both 1. It is never set on a mid-block sample or on an idle cycle.
- R4: With rem = period mod blk_size equal to 0 and N = period / blk_size, a block header with BSN b ≥ start carries sync exactly when (b − start) mod N = 0.
- R5: With rem ≠ 0, the first period begins at start and lasts N+1 blocks. An accumulator begins at blk_size − rem and has rem subtracted at every sync. A negative result makes the next period N+1 blocks and blk_size is added back; otherwise the next period is N blocks. Example: period 10, blk_size 4 puts syncs at start+0, 3, 5, 8, 10.
- R6: A block with BSN below start never carries sync.
- R7: Only bits [30:0] of the BSN take part in the comparison. Higher bits are ignored.
- R8: A block header whose low BSN is greater than the expected sync BSN sets err_o, which stays 1 until reset. That block and any later block carry no sync.
- R9: exp_bsn_o equals start after arming. At each sync it advances by the length of the period just finished. period_blks_o then shows the length of the period that follows.
- R10: For CFG_W cycles after reset release, while N and rem are being derived, block headers carry no sync and do not set err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_start_bsn | input | BSN_W | BSN of the first sync |
| cfg_period | input | CFG_W | Sync period in samples (≥ cfg_blk_size) |
| cfg_blk_size | input | CFG_W | Block size in samples (≥ 1) |
| in_valid | input | 1 | Input sample valid |
| in_sop | input | 1 | First sample of a block |
| in_bsn | input | BSN_W | Block sequence number, read at in_sop |
| in_data | input | DATA_W | Sample data |
| out_valid | output | 1 | Delayed in_valid |
| out_sop | output | 1 | Delayed in_sop |
| out_bsn | output | BSN_W | Delayed in_bsn |
| out_data | output | DATA_W | Delayed in_data |
| out_sync | output | 1 | Sync flag on the block's first sample |
| exp_bsn_o | output | 31 | Next expected sync BSN (low 31 bits) |
| period_blks_o | output | CFG_W | Length in blocks of the coming period |
| err_o | output | 1 | Sticky flag: expected sync BSN was skipped |

## Verification
The sync decision and the period bookkeeping act on the same clock edge. When a header matches, out_sync rises together with the advance of exp_bsn_o and the accumulator's choice of the next period length. The bench checks the status outputs in that same cycle against a loop-based model that replays the remainder sequence from the start BSN. A second collision is between the end of the divider run and an arriving header. The bench sends a header at the start BSN right after reset and expects neither sync nor error. In the skip test, the bench expects err_o to rise in the same cycle that the skipping header is forwarded without sync.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // Number of low BSN bits used in period arithmetic
  localparam int BSN_CMP_W = 31;
  typedef logic [BSN_CMP_W-1:0] bsn_lo_t;
endpackage

// File: rtl/fsync_divider.sv
// Bit-serial restoring divider: quotient and remainder of period / block size.
// Operands are captured while rst is high; done rises after W cycles.
module fsync_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     quo_q;
  logic [W-1:0]     rem_q;
  logic [W-1:0]     den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [W:0]       trial;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= dividend;
      rem_q  <= '0;
      den_q  <= divisor;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (fits) begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(W - 1)) done_q <= 1'b1;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign done      = done_q;
endmodule

// File: rtl/fsync_tracker.sv
// Holds the next expected sync BSN, the current period length and the
// remainder accumulator; flags a match or a skip on each block header.
module fsync_tracker
  import fsync_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  bsn_lo_t          start_lo,
  input  logic [CFG_W-1:0] blk_size,
  input  logic             div_done,
  input  logic [CFG_W-1:0] n_min,
  input  logic [CFG_W-1:0] extra,
  input  logic             hdr,
  input  bsn_lo_t          bsn_lo,
  output logic             sync_hit,
  output bsn_lo_t          exp_bsn,
  output logic [CFG_W-1:0] nof_blk,
  output logic             err
);
  logic                    armed_q;
  bsn_lo_t                 exp_q;
  logic [CFG_W-1:0]        nof_q;
  logic signed [CFG_W:0]   acc_q;
  logic [CFG_W-1:0]        blk_q;
  logic                    err_q;
  logic                    hdr_live;
  logic                    skip;
  logic signed [CFG_W:0]   acc_sub;
  logic signed [CFG_W:0]   blk_s;
  logic signed [CFG_W:0]   extra_s;
  bsn_lo_t                 exp_next;

  always_comb begin
    hdr_live = armed_q & hdr;
    sync_hit = hdr_live & (bsn_lo == exp_q);
    skip     = hdr_live & (bsn_lo > exp_q);
    blk_s    = $signed({1'b0, blk_q});
    extra_s  = $signed({1'b0, extra});
    acc_sub  = acc_q - extra_s;
    exp_next = exp_q + BSN_CMP_W'(nof_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      exp_q   <= start_lo;
      nof_q   <= '0;
      acc_q   <= '0;
      blk_q   <= blk_size;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_q | skip;
      if (div_done && !armed_q) begin
        armed_q <= 1'b1;
        nof_q   <= n_min + CFG_W'(extra != '0);
        acc_q   <= blk_s - extra_s;
      end else if (sync_hit) begin
        exp_q <= exp_next;
        if (acc_sub < 0) begin
          nof_q <= n_min + CFG_W'(1);
          acc_q <= acc_sub + blk_s;
        end else begin
          nof_q <= n_min;
          acc_q <= acc_sub;
        end
      end
    end
  end

  assign exp_bsn = exp_q;
  assign nof_blk = nof_q;
  assign err     = err_q;
endmodule

// File: rtl/fsync_out_stage.sv
// Single output register stage for the stream and the sync flag.
module fsync_out_stage #(
  parameter int BSN_W  = 48,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic [BSN_W-1:0]  bsn_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_i,
  output logic              valid_o,
  output logic              sop_o,
  output logic [BSN_W-1:0]  bsn_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sync_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sop_o   <= sop_i;
      sync_o  <= sync_i;
    end
  end

  always_ff @(posedge clk) begin
    bsn_o  <= bsn_i;
    data_o <= data_i;
  end
endmodule

// File: rtl/frac_sync_marker.sv
module frac_sync_marker
  import fsync_pkg::*;
#(
  parameter int BSN_W  = 48,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BSN_W-1:0]  cfg_start_bsn,
  input  logic [CFG_W-1:0]  cfg_period,
  input  logic [CFG_W-1:0]  cfg_blk_size,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BSN_W-1:0]  in_bsn,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic [BSN_W-1:0]  out_bsn,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sync,
  output logic [30:0]       exp_bsn_o,
  output logic [CFG_W-1:0]  period_blks_o,
  output logic              err_o
);
  logic [CFG_W-1:0] n_min;
  logic [CFG_W-1:0] extra;
  logic             div_done;
  logic             sync_hit;
  bsn_lo_t          exp_bsn;

  fsync_divider #(.W(CFG_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .dividend  (cfg_period),
    .divisor   (cfg_blk_size),
    .quotient  (n_min),
    .remainder (extra),
    .done      (div_done)
  );

  fsync_tracker #(.CFG_W(CFG_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .start_lo (cfg_start_bsn[BSN_CMP_W-1:0]),
    .blk_size (cfg_blk_size),
    .div_done (div_done),
    .n_min    (n_min),
    .extra    (extra),
    .hdr      (in_valid & in_sop),
    .bsn_lo   (in_bsn[BSN_CMP_W-1:0]),
    .sync_hit (sync_hit),
    .exp_bsn  (exp_bsn),
    .nof_blk  (period_blks_o),
    .err      (err_o)
  );

  fsync_out_stage #(.BSN_W(BSN_W), .DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .sop_i   (in_sop),
    .bsn_i   (in_bsn),
    .data_i  (in_data),
    .sync_i  (sync_hit),
    .valid_o (out_valid),
    .sop_o   (out_sop),
    .bsn_o   (out_bsn),
    .data_o  (out_data),
    .sync_o  (out_sync)
  );

  assign exp_bsn_o = exp_bsn;
endmodule

// File: rtl/fsync_checker.sv
module fsync_checker #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_sop,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_sync,
  input logic [30:0]      exp_bsn_o,
  input logic [CFG_W-1:0] period_blks_o,
  input logic             err_o
);
  // R3: sync only on a valid first sample
  p_sync_on_sop_r3: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (out_valid && out_sop));

  // R2: one-cycle delay of valid and sop
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));
  p_sop_delay_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_sop == $past(in_sop)));

  // R8: error is sticky, and no sync as it rises
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  p_no_late_sync_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !out_sync);

  // R9: expected BSN advances by the finished period on sync, else holds
  p_exp_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_sync) |->
      (exp_bsn_o == 31'($past(exp_bsn_o) + 31'($past(period_blks_o)))));
  p_exp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_sync) |-> $stable(exp_bsn_o));
endmodule

bind frac_sync_marker fsync_checker #(.CFG_W(CFG_W)) u_fsync_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_sop        (in_sop),
  .out_valid     (out_valid),
  .out_sop       (out_sop),
  .out_sync      (out_sync),
  .exp_bsn_o     (exp_bsn_o),
  .period_blks_o (period_blks_o),
  .err_o         (err_o)
);

// File: tb/sim_frac_sync_marker.sv
`timescale 1ns/1ps
module sim_frac_sync_marker;
  localparam int BSN_W  = 48;
  localparam int DATA_W = 16;
  localparam int CFG_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [BSN_W-1:0]  cfg_start_bsn = '0;
  logic [CFG_W-1:0]  cfg_period = 32'd10;
  logic [CFG_W-1:0]  cfg_blk_size = 32'd4;
  logic              in_valid = 1'b0;
  logic              in_sop = 1'b0;
  logic [BSN_W-1:0]  in_bsn = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid, out_sop, out_sync, err_o;
  logic [BSN_W-1:0]  out_bsn;
  logic [DATA_W-1:0] out_data;
  logic [30:0]       exp_bsn_o;
  logic [CFG_W-1:0]  period_blks_o;

  int checks = 0;
  int errors = 0;
  longint g_start, g_p, g_b;
  bit done_flag = 0;

  always #4 clk = ~clk;

  frac_sync_marker #(.BSN_W(BSN_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u0 (
    .clk(clk), .rst(rst), .cfg_start_bsn(cfg_start_bsn), .cfg_period(cfg_period),
    .cfg_blk_size(cfg_blk_size), .in_valid(in_valid), .in_sop(in_sop),
    .in_bsn(in_bsn), .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_bsn(out_bsn), .out_data(out_data), .out_sync(out_sync),
    .exp_bsn_o(exp_bsn_o), .period_blks_o(period_blks_o), .err_o(err_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model: does a header with low BSN b carry sync
  function automatic bit is_sync(input longint b);
    longint n, e, eb, nb, acc;
    if (b < g_start) return 0;
    n = g_p / g_b;
    e = g_p % g_b;
    if (e == 0) return ((b - g_start) % n) == 0;
    eb = g_start; nb = n + 1; acc = g_b - e;
    while (eb < b) begin
      eb += nb; nb = n; acc -= e;
      if (acc < 0) begin nb++; acc += g_b; end
    end
    return eb == b;
  endfunction

  // Model: first sync BSN strictly after x
  function automatic longint sync_after(input longint x);
    longint n, e, eb, nb, acc;
    n = g_p / g_b;
    e = g_p % g_b;
    eb = g_start; nb = (e != 0) ? n + 1 : n; acc = g_b - e;
    while (eb <= x) begin
      eb += nb; nb = n; acc -= e;
      if (acc < 0) begin nb++; acc += g_b; end
    end
    return eb;
  endfunction

  // One clock of stimulus; outputs checked just after the edge
  task automatic cyc(input bit v, input bit s, input logic [BSN_W-1:0] b, input bit model_on);
    logic [DATA_W-1:0] d;
    longint lo, nx, nx2;
    bit es;
    d = DATA_W'($urandom);
    in_valid = v; in_sop = s; in_bsn = b; in_data = d;
    lo = longint'(b[30:0]);
    es = v && s && model_on && is_sync(lo);
    @(posedge clk); #1;
    chk(out_valid == v, "R2 valid", out_valid, v);
    if (v) begin
      chk(out_sop == s, "R2 sop", out_sop, s);
      chk(out_bsn == b, "R2 bsn", out_bsn, b);
      chk(out_data == d, "R2 data", out_data, d);
    end
    if (!(v && s)) chk(out_sync == 0, "R3 sync off header", out_sync, 0);
    else chk(out_sync == es, "R4/R5/R6/R7 sync", out_sync, es);
    if (es) begin
      nx = sync_after(lo);
      nx2 = sync_after(nx);
      chk(exp_bsn_o == 31'(nx), "R9 exp bsn", exp_bsn_o, nx);
      chk(period_blks_o == CFG_W'(nx2 - nx), "R9 period", period_blks_o, nx2 - nx);
    end
  endtask

  task automatic blk(input logic [BSN_W-1:0] b, input int len, input bit model_on);
    for (int i = 0; i < len; i++) begin
      if ($urandom % 4 == 0) cyc(0, 0, '0, model_on);
      cyc(1, (i == 0), b, model_on);
    end
  endtask

  task automatic setup(input longint st, input longint p, input longint b, input bit wait_arm);
    g_start = st; g_p = p; g_b = b;
    cfg_start_bsn = BSN_W'(st); cfg_period = CFG_W'(p); cfg_blk_size = CFG_W'(b);
    in_valid = 0; in_sop = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0 && out_sync == 0 && err_o == 0, "R1 in reset", out_valid, 0);
    rst = 0;
    @(posedge clk); #1;
    chk(out_valid == 0 && out_sync == 0 && err_o == 0, "R1 after reset", out_sync, 0);
    if (wait_arm) begin
      repeat (CFG_W + 4) cyc(0, 0, '0, 1);
      chk(exp_bsn_o == 31'(st), "R9 exp at arm", exp_bsn_o, st);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R5 worked example, fractional period 10 over blocks of 4
    setup(5, 10, 4, 1);
    for (int k = 0; k < 30; k++) blk(BSN_W'(k), 4, 1);
    chk(err_o == 0, "R8 no error on clean stream", err_o, 0);

    // R4 whole number of blocks: 12 / 4 = 3
    setup(2, 12, 4, 1);
    for (int k = 0; k < 25; k++) blk(BSN_W'(k), 4, 1);
    chk(err_o == 0, "R8 no error on clean stream", err_o, 0);

    // R7 random configurations with high BSN bits set
    for (int t = 0; t < 4; t++) begin
      longint b, p, st;
      b = 1 + $urandom % 6;
      p = b + $urandom % (4 * b + 3);
      st = $urandom % 8;
      setup(st, p, b, 1);
      for (int k = 0; k < st + 25; k++) blk((BSN_W'(1) << 40) | BSN_W'(k), int'(b), 1);
      chk(err_o == 0, "R7 no error with high bits", err_o, 0);
    end

    // R10 header at start BSN before the divider finishes
    setup(3, 10, 4, 0);
    cyc(1, 1, BSN_W'(3), 0);
    chk(err_o == 0, "R10 no error while deriving", err_o, 0);
    cyc(1, 1, BSN_W'(9), 0);
    chk(err_o == 0, "R10 no error on skip while deriving", err_o, 0);

    // R8 skip over the expected BSN
    setup(4, 8, 4, 1);
    for (int k = 0; k < 3; k++) blk(BSN_W'(k), 4, 1);
    cyc(1, 1, BSN_W'(6), 0);
    chk(err_o == 1, "R8 error on skip", err_o, 1);
    for (int i = 1; i < 4; i++) cyc(1, 0, BSN_W'(6), 0);
    cyc(1, 1, BSN_W'(8), 0);
    chk(err_o == 1, "R8 error sticky", err_o, 1);
    chk(exp_bsn_o == 31'd4, "R8 expected BSN held", exp_bsn_o, 4);
    repeat (3) cyc(0, 0, '0, 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule